// File: doc/BRIEF.md
# Timer Compare Output Unit

This block watches a free-running timer count and compares it against a programmable compare value. When the two become equal, it acts according to a 4-bit mode held in a local register. Depending on the mode, it drives a single output pin high or low, raises a sticky interrupt flag, or emits a one-cycle event pulse. That pulse is meant to clear the external timer and start an analog-to-digital conversion. The timer, the converter and the pad lie outside the block.

Software programs the block through a small write port, which loads either the compare value or the mode. When a compare mode is entered, the pin is first placed at a defined level, so that the later match shows up as a clear transition. A match counts once, on the cycle equality first appears, however long the equality lasts. Mode codes outside the compare group leave the block idle.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the compare value, the mode, the pin, the flag and the event output are all zero. A write with `wr_addr`=0 loads the compare value from `wr_data`. A write with `wr_addr`=1 loads the mode from `wr_data[3:0]`.
- R2: A match is the first clock edge at which `timer_val` equals the registered compare value. An equality that holds over several cycles counts as one match. Rewriting the compare value to the current timer count gives a new match.
- R3: In mode 4'b1000, a match sets `pin_out` high on the following cycle.
- R4: In mode 4'b1001, a match sets `pin_out` low on the following cycle.
- R5: A match in mode 4'b1010 or 4'b1011 leaves `pin_out` unchanged. A match in any mode 4'b0xxx or 4'b11xx changes none of the outputs.
- R6: Writing mode 4'b1000 when the current mode differs drives `pin_out` low on the next cycle.
- R7: Writing mode 4'b1001 while the current mode is outside 4'b10xx drives `pin_out` high on the next cycle. Writing it from another 4'b10xx mode leaves the pin as it is.
- R8: A match in any mode 4'b10xx sets `irq_flag`, and the flag stays set.
- R9: A pulse on `flag_clr` clears `irq_flag`. If a match occurs at the same edge as the clear, the flag stays set.
- R10: A match in mode 4'b1011 raises `evt_pulse` for exactly one cycle. No other mode ever raises it.
- R11: When a mode write and a match occur at the same edge, the match is judged by the mode that was current before the write. The level forced by the mode entry takes priority over the pin action of that match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the compare value, 1 selects the mode |
| wr_data | input | 16 | Write data |
| timer_val | input | 16 | Current timer count |
| flag_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| pin_out | output | 1 | Compare output pin level |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| evt_pulse | output | 1 | One-cycle special-event trigger |

## Verification
The timer is swept slowly across the compare value, held on it, and jumped onto it. Comparing the swept case with the held case shows that a match fires once and is not repeated. Each mode code is entered from compare and from non-compare predecessors, which separates the forced entry levels from the pin actions caused by matches. Mode writes and flag clears are placed on the same edge as a match, which exposes the order of priority between them.

// File: rtl/tcmp_pkg.sv
// Package: shared mode encoding and helper types for the timer compare unit.
// Assumes the mode field is 4 bits wide; the codes below are the behaviour.
package tcmp_pkg;

    localparam int MODE_W = 4;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MD_IDLE    = 4'b0000;
    localparam mode_t MD_DRV_HI  = 4'b1000;
    localparam mode_t MD_DRV_LO  = 4'b1001;
    localparam mode_t MD_FLAG    = 4'b1010;
    localparam mode_t MD_EVENT   = 4'b1011;

    // Pin levels forced when a compare mode is entered.
    typedef struct packed {
        logic force_lo;
        logic force_hi;
    } entry_t;

    // True for the compare group 4'b10xx.
    function automatic logic is_compare(input mode_t m);
        return m[MODE_W-1 -: 2] == 2'b10;
    endfunction

endpackage

// File: rtl/tcmp_regs.sv
// Module: compare value and mode registers, plus detection of mode entry.
// Assumes TMR_W >= the mode width; the mode takes the low bits of wr_data.
// The entry outputs are combinational and valid at the edge of the write.
module tcmp_regs
    import tcmp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic [TMR_W-1:0] cmp_q,
    output mode_t            mode_q,
    output entry_t           entry
);

    mode_t new_mode;
    logic  mode_wr;
    logic  mode_change;

    // Decode the mode write and whether it changes the current mode.
    always_comb begin
        new_mode    = wr_data[MODE_W-1:0];
        mode_wr     = wr_en && wr_addr;
        mode_change = mode_wr && (new_mode != mode_q);
    end

    // Entry levels: a new 1000 forces low, a 1001 entered from outside the group forces high.
    always_comb begin
        entry.force_lo = mode_change && (new_mode == MD_DRV_HI);
        entry.force_hi = mode_change && (new_mode == MD_DRV_LO) && !is_compare(mode_q);
    end

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (wr_en && !wr_addr)
            cmp_q <= wr_data;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MD_IDLE;
        else if (mode_wr)
            mode_q <= new_mode;
    end

    p_cmp_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> cmp_q == $past(wr_data))
        else $error("compare value not loaded");

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr) |=> $stable(mode_q))
        else $error("mode changed without a write");

    p_entry_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(entry.force_lo && entry.force_hi))
        else $error("both entry levels requested");

endmodule

// File: rtl/tcmp_match.sv
// Module: equality detector that reports a match only on the first cycle
// the timer equals the compare value. Assumes both inputs are synchronous.
module tcmp_match #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] timer_val,
    input  logic [TMR_W-1:0] cmp_val,
    output logic             hit
);

    logic eq_now;
    logic eq_last;

    // Compare the two counts.
    always_comb begin
        eq_now = (timer_val == cmp_val);
        hit    = eq_now && !eq_last;
    end

    // Remember the previous equality so that a held equality fires once.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eq_last <= 1'b0;
        else
            eq_last <= eq_now;
    end

    p_one_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit)
        else $error("match repeated on consecutive cycles");

endmodule

// File: rtl/tcmp_action.sv
// Module: output state for the pin, the interrupt flag and the event pulse.
// Assumes mode_q is the mode before any write at the same edge; entry
// forcing takes priority over the pin action of a match.
module tcmp_action
    import tcmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    input  mode_t  mode_q,
    input  entry_t entry,
    input  logic   flag_clr,
    output logic   pin_q,
    output logic   flag_q,
    output logic   evt_q
);

    logic cmp_hit;
    logic no_force;

    // Qualify the match with the compare group.
    always_comb begin
        cmp_hit  = hit && is_compare(mode_q);
        no_force = !entry.force_lo && !entry.force_hi;
    end

    // Pin level: entry forcing first, then the match action of the current mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else if (entry.force_lo)
            pin_q <= 1'b0;
        else if (entry.force_hi)
            pin_q <= 1'b1;
        else if (hit && mode_q == MD_DRV_HI)
            pin_q <= 1'b1;
        else if (hit && mode_q == MD_DRV_LO)
            pin_q <= 1'b0;
    end

    // Sticky flag: a match beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (cmp_hit)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // One-cycle event trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else
            evt_q <= hit && (mode_q == MD_EVENT);
    end

    p_pin_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MD_DRV_HI && no_force) |=> pin_q)
        else $error("pin not high after match");

    p_pin_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_q == MD_DRV_LO && no_force) |=> !pin_q)
        else $error("pin not low after match");

    p_pin_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (mode_q == MD_FLAG || mode_q == MD_EVENT) && no_force) |=> $stable(pin_q))
        else $error("pin moved in a flag-only mode");

    p_entry_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        entry.force_lo |=> !pin_q)
        else $error("pin not low on entry");

    p_entry_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        entry.force_hi |=> pin_q)
        else $error("pin not high on entry");

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> flag_q)
        else $error("flag not set on match");

    p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cmp_hit) |=> !flag_q)
        else $error("flag not cleared");

    p_evt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q)
        else $error("event pulse longer than one cycle");

    p_evt_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(mode_q) == MD_EVENT)
        else $error("event pulse outside event mode");

endmodule

// File: rtl/tcmp_unit.sv
// Module: timer compare output unit top level. Connects the register file,
// the match detector and the output state. Assumes timer_val is synchronous
// to clk and that reset is held for at least one edge.
module tcmp_unit
    import tcmp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic [TMR_W-1:0] timer_val,
    input  logic             flag_clr,
    output logic             pin_out,
    output logic             irq_flag,
    output logic             evt_pulse
);

    logic [TMR_W-1:0] cmp_q;
    mode_t            mode_q;
    entry_t           entry;
    logic             hit;

    tcmp_regs #(.TMR_W(TMR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_q   (cmp_q),
        .mode_q  (mode_q),
        .entry   (entry)
    );

    tcmp_match #(.TMR_W(TMR_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_val (timer_val),
        .cmp_val   (cmp_q),
        .hit       (hit)
    );

    tcmp_action u_action (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .mode_q   (mode_q),
        .entry    (entry),
        .flag_clr (flag_clr),
        .pin_q    (pin_out),
        .flag_q   (irq_flag),
        .evt_q    (evt_pulse)
    );

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !is_compare(mode_q) && !flag_clr) |=> ($stable(irq_flag) && !evt_pulse))
        else $error("idle mode reacted to a match");

endmodule

// File: tb/tcmp_unit_test.sv
// Bench: behavioural reference model updated at each rising edge and
// compared with the outputs at each falling edge.
module tcmp_unit_test;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_addr = 1'b0;
    logic [TW-1:0] wr_data = '0;
    logic [TW-1:0] tmr = '0;
    logic          clr = 1'b0;
    logic          pin, flag, evt;

    always #5 clk = ~clk;

    tcmp_unit #(.TMR_W(TW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .timer_val (tmr),
        .flag_clr  (clr),
        .pin_out   (pin),
        .irq_flag  (flag),
        .evt_pulse (evt)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    armed = 0;
    bit    done = 0;

    // Reference model state.
    int   m_cmp, m_mode;
    logic m_eq_d, m_pin, m_flag, m_evt;

    always @(posedge clk) begin
        logic eq, hit, was_cmp;
        int   nm;
        if (!rst_n) begin
            m_cmp = 0; m_mode = 0; m_eq_d = 0;
            m_pin = 0; m_flag = 0; m_evt = 0;
        end else begin
            eq      = (int'(tmr) == m_cmp);
            hit     = eq && !m_eq_d;
            m_eq_d  = eq;
            was_cmp = (m_mode / 4) == 2;
            m_evt   = hit && (m_mode == 11);
            if (hit && was_cmp) m_flag = 1;
            else if (clr) m_flag = 0;
            nm = int'(wr_data[3:0]);
            if (wr_en && wr_addr && nm != m_mode && nm == 8)
                m_pin = 0;
            else if (wr_en && wr_addr && nm != m_mode && nm == 9 && !was_cmp)
                m_pin = 1;
            else if (hit && m_mode == 8)
                m_pin = 1;
            else if (hit && m_mode == 9)
                m_pin = 0;
            if (wr_en && !wr_addr) m_cmp = int'(wr_data);
            if (wr_en && wr_addr) m_mode = nm;
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", cur_req, what, act, exp);
        end
    endtask

    // Compare every cycle against the model.
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("pin_out", pin, m_pin);
            chk("irq_flag", flag, m_flag);
            chk("evt_pulse", evt, m_evt);
        end
    end

    task automatic put(input logic a, input logic [TW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep(input int from, input int to);
        for (int v = from; v <= to; v++) begin
            tmr = v[TW-1:0];
            @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        chk("reset pin", pin, 1'b0);
        chk("reset flag", flag, 1'b0);
        chk("reset evt", evt, 1'b0);
        armed = 1;
        put(1'b0, 16'h0040);
        put(1'b1, 16'h0000);
        cur_req = "R5";                    // idle mode ignores match
        sweep(16'h3c, 16'h44);
        cur_req = "R6";
        put(1'b1, 16'h0008);
        cur_req = "R3";                    // R8 flag set here as well
        sweep(16'h3e, 16'h42);
        cur_req = "R9";
        pulse_clr();
        cur_req = "R2";                    // held equality fires once
        tmr = 16'h0040;
        repeat (2) @(negedge clk);
        pulse_clr();
        repeat (4) @(negedge clk);
        chk("held equality flag", flag, 1'b0);
        cur_req = "R6";
        put(1'b1, 16'h0000);
        put(1'b1, 16'h0008);
        chk("entry low", pin, 1'b0);
        cur_req = "R7";
        put(1'b1, 16'h0000);
        put(1'b1, 16'h0009);
        chk("entry high", pin, 1'b1);
        cur_req = "R4";
        sweep(16'h3e, 16'h41);
        cur_req = "R7";                    // 1001 from 1000 keeps the pin
        put(1'b1, 16'h0008);
        sweep(16'h3f, 16'h41);
        put(1'b1, 16'h0009);
        sweep(16'h3f, 16'h41);
        cur_req = "R8";
        pulse_clr();
        put(1'b1, 16'h000a);
        sweep(16'h3f, 16'h41);
        pulse_clr();
        cur_req = "R10";
        put(1'b1, 16'h000b);
        sweep(16'h3f, 16'h42);
        cur_req = "R5";
        pulse_clr();
        put(1'b1, 16'h000c);
        sweep(16'h3f, 16'h41);
        put(1'b1, 16'h0002);
        sweep(16'h3f, 16'h41);
        cur_req = "R9";                    // clear loses to match
        put(1'b1, 16'h000a);
        tmr = 16'h003f;
        @(negedge clk);
        tmr = 16'h0040; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("flag kept on clear with match", flag, 1'b1);
        cur_req = "R11";
        put(1'b1, 16'h0000);
        put(1'b1, 16'h0009);
        tmr = 16'h003f;
        @(negedge clk);
        tmr = 16'h0040;
        put(1'b1, 16'h0008);
        chk("entry beats match", pin, 1'b0);
        tmr = 16'h003f;
        @(negedge clk);
        tmr = 16'h0040;
        put(1'b1, 16'h000b);
        chk("old mode acts", pin, 1'b1);
        chk("no event from old mode", evt, 1'b0);
        sweep(16'h3f, 16'h41);
        cur_req = "R2";                    // compare rewritten onto the count
        tmr = 16'h1234;
        repeat (2) @(negedge clk);
        put(1'b0, 16'h1234);
        repeat (3) @(negedge clk);
        cur_req = "R1";                    // mode taken from low bits
        put(1'b1, 16'hfff8);
        sweep(16'h1233, 16'h1235);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule